// File: doc/BRIEF.md
# Headphone Playback Power Sequencer

This block drives a stereo audio codec's headphone playback path through a fixed, pop-free bring-up and teardown. It walks a built-in script of register writes and places each write on a byte-wide write port: an 8-bit register address, 8-bit data, and a valid/ready handshake. A serial bus bridge downstream carries each write to the codec.

Between certain writes the block stops and counts out a settling interval. The first follows the sample-rate write and covers PLL lock. The second follows mute release, while the amplifier common voltage rises. The third follows mute assertion on teardown and lasts twice the fall time constant, so the common voltage reaches ground before the amplifiers lose power.

A start command brings the path up once the clocks are ready. A stop command takes it down from the playing state. Status outputs report when a sequence is in flight and when playback is live, and a one-cycle pulse marks the end of each sequence.

Top module: `pwr_sequencer`

## Requirements
- R1: After reset (asynchronous, active low) the block is idle: `wr_valid`, `busy`, `playing` and `done` are all 0, and no write is pending. A reset in the middle of a sequence abandons it, and the next start begins again at the first write.
- R2: A start command is accepted only when the block is idle and `clk_ready` is 1. With `clk_ready` at 0 it is ignored: `busy` and `wr_valid` stay 0.
- R3: The bring-up script issues exactly these (address, data) writes in this order: (01,F4) (08,A5) (0B,01) (0C,01) (18,0A) (1A,28) (1B,28) (00,C1) (10,63) (10,67), all in hex.
- R4: After the handshake of the (01,F4) write, `wr_valid` stays 0 for exactly PLL_CYC cycles and then rises for the next write.
- R5: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_addr` and `wr_data` hold steady. The script advances only on a cycle where both are 1.
- R6: The (10,67) write sets register 10's bit 2, the mute-release bit. After its handshake, exactly RISE_CYC cycles pass with `playing` at 0. Then `playing` goes to 1 and `done` pulses in the same cycle.
- R7: Stop is accepted only while playing, and start only while idle. Either command in any other state has no effect on the writes, their order or the status.
- R8: The teardown script issues exactly these writes in this order: (10,63) (10,00) (00,01) (18,02) (0B,00) (0C,00), all in hex.
- R9: After the handshake of the teardown (10,63) write, `wr_valid` stays 0 for exactly 2×FALL_CYC cycles before the (10,00) write appears.
- R10: `done` is a single-cycle pulse. After the last teardown handshake, `done` pulses with `busy` and `playing` at 0, and the block is idle again.
- R11: `busy` is 1 from the cycle after a start or stop is accepted until the sequence finishes, and `busy` and `playing` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ready | input | 1 | Codec clocks are running; gates start |
| start_cmd | input | 1 | Request bring-up (one-cycle pulse) |
| stop_cmd | input | 1 | Request teardown (one-cycle pulse) |
| wr_valid | output | 1 | Register write is offered |
| wr_ready | input | 1 | Downstream accepts the write |
| wr_addr | output | 8 | Register address of the offered write |
| wr_data | output | 8 | Register data of the offered write |
| busy | output | 1 | A bring-up or teardown is in progress |
| playing | output | 1 | Path is up and unmuted |
| done | output | 1 | One-cycle pulse at the end of each sequence |

## Verification
The bench builds the block with PLL_CYC=5, RISE_CYC=7 and FALL_CYC=4, so the three waits last 5, 7 and 8 cycles. At the real-time defaults these waits run to millions of cycles. With these values, each wait can be counted cycle by cycle. Because the three lengths all differ, a swapped wait source or a missing doubling of the fall hold shows up as a wrong gap. Handshake stalls of several lengths, and commands sent in states that must ignore them, exercise the hold and ignore rules on every path.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  localparam int IDX_W    = 4;
  localparam int MUTE_BIT = 2;

  typedef enum logic [1:0] {WT_NONE, WT_PLL, WT_RISE, WT_FALL} wait_e;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] data;
    wait_e      hold;
    logic       last;
  } step_t;

  localparam logic [7:0] AMP_ON   = 8'h63;
  localparam logic [7:0] AMP_PLAY = AMP_ON | 8'(1 << MUTE_BIT);

  function automatic step_t mk_step(input logic [7:0] a, input logic [7:0] d,
                                    input wait_e w, input logic l);
    step_t s;
    s.addr = a;
    s.data = d;
    s.hold = w;
    s.last = l;
    return s;
  endfunction

endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R4/R6/R9: a running wait drains one step per cycle and never skips ahead
  p_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !expired) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/pwrseq_script.sv
module pwrseq_script
  import pwrseq_pkg::*;
(
  input  logic             dir_down,
  input  logic [IDX_W-1:0] idx,
  output step_t            step
);

  always_comb begin
    step = mk_step(8'h00, 8'h00, WT_NONE, 1'b1);
    if (!dir_down) begin
      case (idx)
        4'd0: step = mk_step(8'h01, 8'hF4, WT_PLL,  1'b0);
        4'd1: step = mk_step(8'h08, 8'hA5, WT_NONE, 1'b0);
        4'd2: step = mk_step(8'h0B, 8'h01, WT_NONE, 1'b0);
        4'd3: step = mk_step(8'h0C, 8'h01, WT_NONE, 1'b0);
        4'd4: step = mk_step(8'h18, 8'h0A, WT_NONE, 1'b0);
        4'd5: step = mk_step(8'h1A, 8'h28, WT_NONE, 1'b0);
        4'd6: step = mk_step(8'h1B, 8'h28, WT_NONE, 1'b0);
        4'd7: step = mk_step(8'h00, 8'hC1, WT_NONE, 1'b0);
        4'd8: step = mk_step(8'h10, AMP_ON,   WT_NONE, 1'b0);
        4'd9: step = mk_step(8'h10, AMP_PLAY, WT_RISE, 1'b1);
        default: step = mk_step(8'h00, 8'h00, WT_NONE, 1'b1);
      endcase
    end else begin
      case (idx)
        4'd0: step = mk_step(8'h10, AMP_ON, WT_FALL, 1'b0);
        4'd1: step = mk_step(8'h10, 8'h00, WT_NONE, 1'b0);
        4'd2: step = mk_step(8'h00, 8'h01, WT_NONE, 1'b0);
        4'd3: step = mk_step(8'h18, 8'h02, WT_NONE, 1'b0);
        4'd4: step = mk_step(8'h0B, 8'h00, WT_NONE, 1'b0);
        4'd5: step = mk_step(8'h0C, 8'h00, WT_NONE, 1'b1);
        default: step = mk_step(8'h00, 8'h00, WT_NONE, 1'b1);
      endcase
    end
  end

endmodule

// File: rtl/pwr_sequencer.sv
module pwr_sequencer
  import pwrseq_pkg::*;
#(
  parameter int unsigned PLL_CYC  = 240000,
  parameter int unsigned RISE_CYC = 3000000,
  parameter int unsigned FALL_CYC = 3000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_ready,
  input  logic       start_cmd,
  input  logic       stop_cmd,
  output logic       wr_valid,
  input  logic       wr_ready,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       busy,
  output logic       playing,
  output logic       done
);

  localparam int unsigned FALL_HOLD = 2 * FALL_CYC;
  localparam int unsigned MAX_AB    = (PLL_CYC > RISE_CYC) ? PLL_CYC : RISE_CYC;
  localparam int unsigned MAX_WAIT  = (MAX_AB > FALL_HOLD) ? MAX_AB : FALL_HOLD;
  localparam int          CNT_W     = $clog2(MAX_WAIT + 1);

  typedef enum logic [1:0] {S_IDLE, S_WRITE, S_WAIT, S_PLAY} st_e;

  st_e              st_q, st_d;
  logic             dir_q, dir_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;
  logic             tmr_load, tmr_exp;
  logic [CNT_W-1:0] tmr_val;
  step_t            step;

  pwrseq_script u_script (
    .dir_down (dir_q),
    .idx      (idx_q),
    .step     (step)
  );

  pwrseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  always_comb begin
    case (step.hold)
      WT_PLL:  tmr_val = CNT_W'(PLL_CYC - 1);
      WT_RISE: tmr_val = CNT_W'(RISE_CYC - 1);
      WT_FALL: tmr_val = CNT_W'(FALL_HOLD - 1);
      default: tmr_val = '0;
    endcase
  end

  always_comb begin
    st_d     = st_q;
    dir_d    = dir_q;
    idx_d    = idx_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (start_cmd && clk_ready) begin
          st_d  = S_WRITE;
          dir_d = 1'b0;
          idx_d = '0;
        end
      end
      S_WRITE: begin
        if (wr_ready) begin
          if (step.hold != WT_NONE) begin
            st_d     = S_WAIT;
            tmr_load = 1'b1;
          end else if (step.last) begin
            st_d   = S_IDLE;
            done_d = 1'b1;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
      S_WAIT: begin
        if (tmr_exp) begin
          if (step.last) begin
            st_d   = S_PLAY;
            done_d = 1'b1;
          end else begin
            st_d  = S_WRITE;
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
      S_PLAY: begin
        if (stop_cmd) begin
          st_d  = S_WRITE;
          dir_d = 1'b1;
          idx_d = '0;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      dir_q  <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      dir_q  <= dir_d;
      idx_q  <= idx_d;
      done_q <= done_d;
    end
  end

  assign wr_valid = (st_q == S_WRITE);
  assign wr_addr  = step.addr;
  assign wr_data  = step.data;
  assign busy     = (st_q == S_WRITE) || (st_q == S_WAIT);
  assign playing  = (st_q == S_PLAY);
  assign done     = done_q;

  // R5: an offered write stays put until it is taken
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R10: done lasts a single cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: in-flight and playing are exclusive
  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && playing));

  // R2: a bring-up only begins when clocks were ready
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !$past(playing)) |-> $past(clk_ready));

  // R7: leaving playback needs a stop command
  p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(playing) |-> $past(stop_cmd));

endmodule

// File: tb/tb_pwr_sequencer.sv
`timescale 1ns/1ps
module tb_pwr_sequencer;

  localparam int unsigned PLL_T  = 5;
  localparam int unsigned RISE_T = 7;
  localparam int unsigned FALL_T = 4;
  localparam int          NSTEP  = 16;

  // {act[1:0], dly[3:0], addr[7:0], data[7:0], gap[7:0]}
  // act: 0 none, 1 start before, 2 stop before, 3 stray commands during stall
  localparam logic [29:0] TBL [NSTEP] = '{
    {2'd1, 4'd0, 8'h01, 8'hF4, 8'(PLL_T)},
    {2'd0, 4'd2, 8'h08, 8'hA5, 8'd0},
    {2'd3, 4'd3, 8'h0B, 8'h01, 8'd0},
    {2'd0, 4'd0, 8'h0C, 8'h01, 8'd0},
    {2'd0, 4'd1, 8'h18, 8'h0A, 8'd0},
    {2'd0, 4'd0, 8'h1A, 8'h28, 8'd0},
    {2'd0, 4'd4, 8'h1B, 8'h28, 8'd0},
    {2'd0, 4'd0, 8'h00, 8'hC1, 8'd0},
    {2'd0, 4'd2, 8'h10, 8'h63, 8'd0},
    {2'd0, 4'd0, 8'h10, 8'h67, 8'(RISE_T)},
    {2'd2, 4'd1, 8'h10, 8'h63, 8'(2*FALL_T)},
    {2'd0, 4'd0, 8'h10, 8'h00, 8'd0},
    {2'd3, 4'd2, 8'h00, 8'h01, 8'd0},
    {2'd0, 4'd0, 8'h18, 8'h02, 8'd0},
    {2'd0, 4'd1, 8'h0B, 8'h00, 8'd0},
    {2'd0, 4'd0, 8'h0C, 8'h00, 8'd0}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       clk_ready, start_cmd, stop_cmd, wr_ready;
  logic       wr_valid, busy, playing, done;
  logic [7:0] wr_addr, wr_data;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  pwr_sequencer #(.PLL_CYC(PLL_T), .RISE_CYC(RISE_T), .FALL_CYC(FALL_T)) dut (
    .clk(clk), .rst_n(rst_n), .clk_ready(clk_ready), .start_cmd(start_cmd),
    .stop_cmd(stop_cmd), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .playing(playing),
    .done(done)
  );

  task automatic chk(input logic ok, input string rq, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    start_cmd = 1'b1;
    @(negedge clk);
    start_cmd = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_cmd = 1'b1;
    @(negedge clk);
    stop_cmd = 1'b0;
  endtask

  task automatic do_step(input int i);
    logic [1:0] act;
    logic [3:0] dly;
    logic [7:0] ea, ed;
    int         eg, g;
    string      rq;
    {act, dly, ea, ed} = TBL[i][29:8];
    eg = int'(TBL[i][7:0]);
    rq = (i < 10) ? "R3" : "R8";
    if (act == 2'd1) pulse_start();
    if (act == 2'd2) begin
      pulse_start();                       // R7: start while playing ignored
      repeat (2) @(negedge clk);
      chk(playing && !wr_valid && !busy, "R7", "start in playing", {playing, wr_valid}, 2'b10);
      pulse_stop();
    end
    g = 0;
    while (!wr_valid && g < 50) begin g++; @(negedge clk); end
    chk(wr_valid, rq, "write offered", wr_valid, 1);
    chk(wr_addr == ea, rq, "addr", wr_addr, ea);
    chk(wr_data == ed, rq, "data", wr_data, ed);
    chk(busy && !playing, "R11", "busy during write", {busy, playing}, 2'b10);
    for (int k = 0; k < int'(dly); k++) begin
      stop_cmd  = (act == 2'd3) && (k == 0);
      start_cmd = (act == 2'd3) && (k == 1);
      @(negedge clk);
      stop_cmd  = 1'b0;
      start_cmd = 1'b0;
      chk(wr_valid && wr_addr == ea && wr_data == ed, "R5", "stall hold",
          {wr_valid, wr_addr, wr_data}, {1'b1, ea, ed});
    end
    wr_ready = 1'b1;
    @(negedge clk);
    wr_ready = 1'b0;
    g = 0;
    while (!wr_valid && !done && g < 100) begin g++; @(negedge clk); end
    if (i == 0)  chk(g == eg, "R4", "pll gap", g, eg);
    else if (i == 9)  chk(g == eg, "R6", "rise gap", g, eg);
    else if (i == 10) chk(g == eg, "R9", "fall gap", g, eg);
    else chk(g == eg, rq, "no gap", g, eg);
    if (i == 9) begin
      chk(playing && done && !busy, "R6", "playing with done", {playing, done, busy}, 3'b110);
      @(negedge clk);
      chk(!done && playing, "R10", "done one cycle", done, 0);
    end
    if (i == NSTEP - 1) begin
      chk(done && !busy && !playing && !wr_valid, "R10", "teardown end",
          {done, busy, playing, wr_valid}, 4'b1000);
      @(negedge clk);
      chk(!done, "R10", "done one cycle", done, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clk_ready = 1'b0; start_cmd = 1'b0; stop_cmd = 1'b0; wr_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(!wr_valid && !busy && !playing && !done, "R1", "reset state",
        {wr_valid, busy, playing, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    pulse_start();                          // R2: clocks not ready
    repeat (3) @(negedge clk);
    chk(!busy && !wr_valid, "R2", "start without clocks", {busy, wr_valid}, 0);
    pulse_stop();                           // R7: stop in idle
    repeat (2) @(negedge clk);
    chk(!busy && !wr_valid && !playing, "R7", "stop in idle", {busy, wr_valid, playing}, 0);

    clk_ready = 1'b1;
    for (int i = 0; i < NSTEP; i++) do_step(i);

    repeat (2) @(negedge clk);
    chk(!busy && !wr_valid && !playing, "R10", "idle after teardown", {busy, wr_valid, playing}, 0);

    // R1: reset mid-sequence, then restart from the first write
    pulse_start();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!wr_valid && !busy, "R1", "reset mid-sequence", {wr_valid, busy}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!wr_valid && !busy, "R1", "no resume after reset", {wr_valid, busy}, 0);
    pulse_start();
    chk(wr_valid && wr_addr == 8'h01 && wr_data == 8'hF4, "R1", "restart at first write",
        {wr_addr, wr_data}, 16'h01F4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule